// File: doc/BRIEF.md
# Four-Port GPIO Block with Buzzer Output Override

This block holds four 8-bit bidirectional I/O ports for a small microcontroller. Each port has a direction register, where 1 selects input and 0 selects output, and an output data latch. A per-bit pull-up strap enables the pull-up on any bit that is in input mode. A single register bus reads and writes both registers of every port. The same bus also performs bit-set, bit-clear and complement operations. Each of these reads the port's current view, changes it and writes the result back into the addressed register in one clock cycle.

Port C implements only bits 5:0 and port D only bit 0. The missing bits read as zero, cannot be written and never drive a pad. Port A lines with wake-up enabled raise a wake request when an input pad falls. Three pad inputs are passed straight through to their alternate users: two timer clocks and an external interrupt.

When the buzzer strap is set, the output values of PB0 and PB1 come from a complementary pair instead of from the latches. The pair is derived from a divider that toggles on every timer-0 overflow. Bit 0 of the port B latch alone gates the pair on or off.

Top module: `gpio_ports`

## Requirements
- R1: After reset every direction register reads as its implemented-bit mask (A=FF, B=FF, C=3F, D=01), every data latch holds that same mask, all output enables are 0 and the buzzer divider is 0.
- R2: A bus write with busAddr = {port, 1'b1} loads that port's direction register, and padOe of that port equals the inverted direction bits from the next cycle on. Port code: 0=A, 1=B, 2=C, 3=D.
- R3: A read with busAddr = {port, 1'b0} returns the pad level for input-mode bits and the latch value for output-mode bits.
- R4: With busRmw high and busWr low, rmwOp 1 sets bit rmwBit, rmwOp 2 clears bit rmwBit, and rmwOp 3 inverts all bits of the value R3 would return. The result is written to the addressed register at the next clock edge. An input-mode bit therefore receives its pad level.
- R5: Port C bits 7:6 and port D bits 7:1 read as 0, ignore writes, and hold padOut and padOe at 0.
- R6: pullUp of a bit is 1 exactly when its pull-up strap is 1 and the bit is in input mode.
- R7: wakeReq goes high for one cycle, at the clock edge where it is observed, when a port A bit that is in input mode and has its wake enable set is sampled at 0 after having been sampled at 1. A falling pad on an output-mode bit or on a bit whose wake enable is clear does not raise wakeReq.
- R8: With the buzzer strap clear, padOutB[1:0] follow latch bits 1:0.
- R9: With the buzzer strap set and latch bit B0 at 1, padOutB[0] equals the divider and padOutB[1] equals its inverse. The divider toggles at the clock edge on which tmrOvf is high.
- R10: With the buzzer strap set and latch bit B0 at 0, padOutB[1:0] are both 0 whatever latch bit B1 holds.
- R11: PB0 and PB1 in input mode read their pad levels whether or not the buzzer strap is set.
- R12: tmr0Clk follows padInC[0], tmr1Clk follows padInC[5] and extInt follows padInD[0], with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Bits 2:1 select the port, bit 0 selects direction (1) or data (0) |
| busWr | input | 1 | Plain write strobe |
| busRmw | input | 1 | Read-modify-write strobe; ignored when busWr is high |
| rmwOp | input | 2 | 1 set bit, 2 clear bit, 3 complement all |
| rmwBit | input | 3 | Bit index for set and clear |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data of the addressed register |
| padInA | input | 8 | Port A pad levels |
| padInB | input | 8 | Port B pad levels |
| padInC | input | 8 | Port C pad levels |
| padInD | input | 8 | Port D pad levels |
| padOutA | output | 8 | Port A output values |
| padOutB | output | 8 | Port B output values, bits 1:0 subject to the buzzer |
| padOutC | output | 8 | Port C output values |
| padOutD | output | 8 | Port D output values |
| padOeA | output | 8 | Port A output enables |
| padOeB | output | 8 | Port B output enables |
| padOeC | output | 8 | Port C output enables |
| padOeD | output | 8 | Port D output enables |
| puStrapA | input | 8 | Port A pull-up straps |
| puStrapB | input | 8 | Port B pull-up straps |
| puStrapC | input | 8 | Port C pull-up straps |
| puStrapD | input | 8 | Port D pull-up straps |
| pullUpA | output | 8 | Port A pull-up enables |
| pullUpB | output | 8 | Port B pull-up enables |
| pullUpC | output | 8 | Port C pull-up enables |
| pullUpD | output | 8 | Port D pull-up enables |
| wakeEnA | input | 8 | Port A wake-up enables |
| wakeReq | output | 1 | Registered wake-up request |
| buzzStrap | input | 1 | Buzzer override strap for PB0/PB1 |
| tmrOvf | input | 1 | Timer-0 overflow pulse |
| tmr0Clk | output | 1 | Timer-0 external clock tap |
| tmr1Clk | output | 1 | Timer-1 external clock tap |
| extInt | output | 1 | External interrupt tap |

## Verification
Reads, pull-up enables, the shared-pin taps and the buzzer gating are combinational. The bench therefore samples them 1 ns after it changes an address or a pad, well before the next edge. Register writes, read-modify-write results, the divider toggle and the wake request appear one clock edge after the strobe or pad change. The bench checks each of these just after the following falling edge, or 1 ns after the rising edge. The wake request is also checked one edge later to confirm it lasts only one cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  parameter int PORT_W = 8;

  typedef enum logic [1:0] {
    RMW_NONE = 2'd0,
    RMW_SET  = 2'd1,
    RMW_CLR  = 2'd2,
    RMW_CPL  = 2'd3
  } rmwOp_e;

  // Strobes from the bus control into the register datapath.
  typedef struct packed {
    logic [3:0]        dataWr;
    logic [3:0]        dirWr;
    logic [PORT_W-1:0] wdata;
  } strobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int W     = PORT_W,
  localparam int AW   = $clog2(NPORT) + 1,
  localparam int BW   = $clog2(W)
) (
  input  logic [AW-1:0] busAddr,
  input  logic          busWr,
  input  logic          busRmw,
  input  logic [1:0]    rmwOp,
  input  logic [BW-1:0] rmwBit,
  input  logic [W-1:0]  busWdata,
  input  logic [W-1:0]  curVal,
  output strobe_t       strb
);
  logic [W-1:0] bitOne;
  logic [W-1:0] modVal;
  logic         wen;
  rmwOp_e       op;

  assign op     = rmwOp_e'(rmwOp);
  assign bitOne = W'(1) << rmwBit;

  always_comb begin
    unique case (op)
      RMW_SET:  modVal = curVal | bitOne;
      RMW_CLR:  modVal = curVal & ~bitOne;
      RMW_CPL:  modVal = ~curVal;
      default:  modVal = curVal;
    endcase
  end

  assign wen = busWr | (busRmw & (op != RMW_NONE));

  always_comb begin
    strb.wdata  = busWr ? busWdata : modVal;
    strb.dataWr = '0;
    strb.dirWr  = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (wen && (busAddr[AW-1:1] == (AW-1)'(p))) begin
        if (busAddr[0]) strb.dirWr[p]  = 1'b1;
        else            strb.dataWr[p] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_dp.sv
module gpio_dp
  import gpio_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int W     = PORT_W,
  parameter logic [NPORT-1:0][W-1:0] PORT_MASK = '1,
  localparam int PW   = $clog2(NPORT)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic [PW-1:0]              rdPort,
  input  logic                       rdDir,
  input  logic [NPORT-1:0][W-1:0]    padIn,
  input  logic [NPORT-1:0][W-1:0]    puStrap,
  input  logic [W-1:0]               wakeEn,
  input  logic                       buzzStrap,
  input  logic                       tmrOvf,
  output logic [W-1:0]               curVal,
  output logic [NPORT-1:0][W-1:0]    padOut,
  output logic [NPORT-1:0][W-1:0]    padOe,
  output logic [NPORT-1:0][W-1:0]    pullUp,
  output logic                       wakeReq
);
  logic [NPORT-1:0][W-1:0] dataQ;
  logic [NPORT-1:0][W-1:0] dirQ;
  logic [NPORT-1:0][W-1:0] viewVal;
  logic [W-1:0]            prevA;
  logic                    pfdQ;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataQ[p] <= PORT_MASK[p];
        dirQ[p]  <= PORT_MASK[p];
      end else begin
        if (strb.dataWr[p]) dataQ[p] <= strb.wdata & PORT_MASK[p];
        if (strb.dirWr[p])  dirQ[p]  <= strb.wdata & PORT_MASK[p];
      end
    end
    assign viewVal[p] = ((dirQ[p] & padIn[p]) | (~dirQ[p] & dataQ[p])) & PORT_MASK[p];
    assign padOe[p]   = ~dirQ[p] & PORT_MASK[p];
    assign pullUp[p]  = puStrap[p] & dirQ[p];
  end

  assign curVal = rdDir ? dirQ[rdPort] : viewVal[rdPort];

  // Divider toggled by timer overflow
  always_ff @(posedge clk) begin
    if (!rstN)       pfdQ <= 1'b0;
    else if (tmrOvf) pfdQ <= ~pfdQ;
  end

  always_comb begin
    padOut = dataQ;
    if (buzzStrap) begin
      padOut[1][0] = dataQ[1][0] & pfdQ;
      padOut[1][1] = dataQ[1][0] & ~pfdQ;
    end
  end

  // Port A falling-edge wake detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevA   <= '0;
      wakeReq <= 1'b0;
    end else begin
      prevA   <= padIn[0] & PORT_MASK[0];
      wakeReq <= |(prevA & ~padIn[0] & dirQ[0] & wakeEn);
    end
  end
endmodule

// File: rtl/gpio_ports.sv
module gpio_ports
  import gpio_pkg::*;
#(
  parameter logic [7:0] MASK_A = 8'hFF,
  parameter logic [7:0] MASK_B = 8'hFF,
  parameter logic [7:0] MASK_C = 8'h3F,
  parameter logic [7:0] MASK_D = 8'h01
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] busAddr,
  input  logic       busWr,
  input  logic       busRmw,
  input  logic [1:0] rmwOp,
  input  logic [2:0] rmwBit,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic [7:0] padInA,
  input  logic [7:0] padInB,
  input  logic [7:0] padInC,
  input  logic [7:0] padInD,
  output logic [7:0] padOutA,
  output logic [7:0] padOutB,
  output logic [7:0] padOutC,
  output logic [7:0] padOutD,
  output logic [7:0] padOeA,
  output logic [7:0] padOeB,
  output logic [7:0] padOeC,
  output logic [7:0] padOeD,
  input  logic [7:0] puStrapA,
  input  logic [7:0] puStrapB,
  input  logic [7:0] puStrapC,
  input  logic [7:0] puStrapD,
  output logic [7:0] pullUpA,
  output logic [7:0] pullUpB,
  output logic [7:0] pullUpC,
  output logic [7:0] pullUpD,
  input  logic [7:0] wakeEnA,
  output logic       wakeReq,
  input  logic       buzzStrap,
  input  logic       tmrOvf,
  output logic       tmr0Clk,
  output logic       tmr1Clk,
  output logic       extInt
);
  localparam int NPORT = 4;
  localparam int W     = 8;
  localparam logic [NPORT-1:0][W-1:0] MASKS = {MASK_D, MASK_C, MASK_B, MASK_A};

  strobe_t                 strb;
  logic [W-1:0]            curVal;
  logic [NPORT-1:0][W-1:0] padInArr, puArr, outArr, oeArr, puOutArr;

  assign padInArr = {padInD, padInC, padInB, padInA};
  assign puArr    = {puStrapD, puStrapC, puStrapB, puStrapA};

  gpio_ctrl #(.NPORT(NPORT), .W(W)) ctrl_i (
    .busAddr(busAddr), .busWr(busWr), .busRmw(busRmw), .rmwOp(rmwOp),
    .rmwBit(rmwBit), .busWdata(busWdata), .curVal(curVal), .strb(strb)
  );

  gpio_dp #(.NPORT(NPORT), .W(W), .PORT_MASK(MASKS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdPort(busAddr[2:1]),
    .rdDir(busAddr[0]), .padIn(padInArr), .puStrap(puArr), .wakeEn(wakeEnA),
    .buzzStrap(buzzStrap), .tmrOvf(tmrOvf), .curVal(curVal), .padOut(outArr),
    .padOe(oeArr), .pullUp(puOutArr), .wakeReq(wakeReq)
  );

  assign busRdata = curVal;
  assign {padOutD, padOutC, padOutB, padOutA} = outArr;
  assign {padOeD, padOeC, padOeB, padOeA}     = oeArr;
  assign {pullUpD, pullUpC, pullUpB, pullUpA} = puOutArr;

  assign tmr0Clk = padInC[0];
  assign tmr1Clk = padInC[5];
  assign extInt  = padInD[0];
endmodule

// File: rtl/gpio_ports_chk.sv
module gpio_ports_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] busAddr,
  input logic       busWr,
  input logic [7:0] busWdata,
  input logic [7:0] busRdata,
  input logic [7:0] padInA,
  input logic [7:0] padInC,
  input logic [7:0] padInD,
  input logic [7:0] padOutB,
  input logic [7:0] padOutD,
  input logic [7:0] padOeA,
  input logic [7:0] padOeC,
  input logic [7:0] padOeD,
  input logic [7:0] wakeEnA,
  input logic       wakeReq,
  input logic       buzzStrap,
  input logic       tmrOvf,
  input logic       tmr0Clk,
  input logic       tmr1Clk,
  input logic       extInt
);
  // R2
  dir_write_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'b001) |=> (padOeA == ~$past(busWdata)));

  // R5
  unimpl_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padOeC[7:6] == 2'b00) && (padOeD[7:1] == 7'h0) && (padOutD[7:1] == 7'h0));

  // R5
  unimpl_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[2:1] == 2'd2) |-> (busRdata[7:6] == 2'b00));

  // R7
  wake_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> ($past(~padInA & wakeEnA & ~padOeA) != 8'h00));

  // R10
  buzz_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    buzzStrap |-> !(padOutB[0] && padOutB[1]));

  // R9
  buzz_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (buzzStrap && !tmrOvf && padOutB[1:0] != 2'b00) |=>
      (!buzzStrap || padOutB[1:0] == 2'b00 || $stable(padOutB[1:0])));

  // R12
  shared_tap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tmr0Clk == padInC[0]) && (tmr1Clk == padInC[5]) && (extInt == padInD[0]));
endmodule

bind gpio_ports gpio_ports_chk chk_i (.*);

// File: tb/gpio_ports_tb_top.sv
`timescale 1ns/1ps
module gpio_ports_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic busWr = 1'b0, busRmw = 1'b0;
  logic [1:0] rmwOp = '0;
  logic [2:0] rmwBit = '0;
  logic [7:0] busWdata = '0, busRdata;
  logic [7:0] padInA = 8'hFF, padInB = 8'hFF, padInC = 8'h00, padInD = 8'h00;
  logic [7:0] padOutA, padOutB, padOutC, padOutD;
  logic [7:0] padOeA, padOeB, padOeC, padOeD;
  logic [7:0] puStrapA = '0, puStrapB = '0, puStrapC = '0, puStrapD = '0;
  logic [7:0] pullUpA, pullUpB, pullUpC, pullUpD;
  logic [7:0] wakeEnA = '0;
  logic wakeReq, buzzStrap = 1'b0, tmrOvf = 1'b0;
  logic tmr0Clk, tmr1Clk, extInt;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ports dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rmw(input logic [2:0] a, input logic [1:0] op, input logic [2:0] b);
    @(negedge clk);
    busAddr = a; rmwOp = op; rmwBit = b; busRmw = 1'b1;
    @(negedge clk);
    busRmw = 1'b0; rmwOp = 2'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'b001, v); chk("R1 dirA", v, 8'hFF);
    rd(3'b011, v); chk("R1 dirB", v, 8'hFF);
    rd(3'b101, v); chk("R1 dirC", v, 8'h3F);
    rd(3'b111, v); chk("R1 dirD", v, 8'h01);
    chk("R1 latchA", padOutA, 8'hFF);
    chk("R1 latchC", padOutC, 8'h3F);
    chk("R1 oeA", padOeA, 8'h00);
    chk("R1 oeD", padOeD, 8'h00);
  endtask

  task automatic t_dir();
    logic [7:0] v;
    wr(3'b001, 8'h0F);
    chk("R2 oeA", padOeA, 8'hF0);
    rd(3'b001, v); chk("R2 dirA readback", v, 8'h0F);
  endtask

  task automatic t_read();
    logic [7:0] v;
    padInA = 8'h5A;
    wr(3'b000, 8'h33);
    rd(3'b000, v); chk("R3 mixed read", v, 8'h3A);
  endtask

  task automatic t_rmw();
    logic [7:0] v;
    rmw(3'b000, 2'd1, 3'd7);
    chk("R4 set bit7", padOutA, 8'hBA);
    rmw(3'b000, 2'd2, 3'd5);
    chk("R4 clear bit5", padOutA, 8'h9A);
    rmw(3'b000, 2'd3, 3'd0);
    chk("R4 complement", padOutA, 8'h65);
    wr(3'b001, 8'h00);
    rd(3'b000, v); chk("R4 latch after rmw", v, 8'h65);
    rmw(3'b001, 2'd1, 3'd2);
    rd(3'b001, v); chk("R4 set on dir reg", v, 8'h04);
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    wr(3'b101, 8'h00);
    wr(3'b100, 8'hFF);
    chk("R5 padOutC", padOutC, 8'h3F);
    chk("R5 oeC", padOeC, 8'h3F);
    wr(3'b101, 8'hFF);
    rd(3'b101, v); chk("R5 dirC read", v, 8'h3F);
    wr(3'b110, 8'hFE);
    wr(3'b111, 8'h00);
    rd(3'b110, v); chk("R5 dataD read", v, 8'h00);
    chk("R5 padOutD", padOutD, 8'h00);
    chk("R5 oeD", padOeD, 8'h01);
  endtask

  task automatic t_pull();
    puStrapA = 8'hF0;
    wr(3'b001, 8'h3C);
    chk("R6 pullUpA", pullUpA, 8'h30);
    puStrapC = 8'hFF;
    #1 chk("R6 pullUpC", pullUpC, 8'h3F);
  endtask

  task automatic t_wake();
    wr(3'b001, 8'hFF);
    wakeEnA = 8'h01;
    padInA = 8'hFF;
    @(negedge clk); @(negedge clk);
    padInA = 8'hFE;
    @(posedge clk); #1 chk("R7 wake raised", {7'h0, wakeReq}, 8'h01);
    @(posedge clk); #1 chk("R7 wake one cycle", {7'h0, wakeReq}, 8'h00);
    @(negedge clk); padInA = 8'hFF;
    @(negedge clk); padInA = 8'hFD;
    @(posedge clk); #1 chk("R7 disabled bit no wake", {7'h0, wakeReq}, 8'h00);
    @(negedge clk); padInA = 8'hFF;
    wr(3'b001, 8'hFE);
    @(negedge clk); padInA = 8'hFE;
    @(posedge clk); #1 chk("R7 output bit no wake", {7'h0, wakeReq}, 8'h00);
    @(negedge clk); padInA = 8'hFF;
  endtask

  task automatic t_buzz_off();
    buzzStrap = 1'b0;
    wr(3'b011, 8'h00);
    wr(3'b010, 8'h02);
    chk("R8 latch drives PB1:0", {6'h0, padOutB[1:0]}, 8'h02);
  endtask

  task automatic t_buzz_on();
    wr(3'b010, 8'h01);
    @(negedge clk); buzzStrap = 1'b1;
    #1 chk("R9 divider low", {6'h0, padOutB[1:0]}, 8'h02);
    @(negedge clk); tmrOvf = 1'b1;
    @(negedge clk); tmrOvf = 1'b0;
    #1 chk("R9 after one overflow", {6'h0, padOutB[1:0]}, 8'h01);
    @(negedge clk); @(negedge clk);
    chk("R9 holds without overflow", {6'h0, padOutB[1:0]}, 8'h01);
    @(negedge clk); tmrOvf = 1'b1;
    @(negedge clk); tmrOvf = 1'b0;
    #1 chk("R9 after two overflows", {6'h0, padOutB[1:0]}, 8'h02);
  endtask

  task automatic t_buzz_gate();
    wr(3'b010, 8'h02);
    chk("R10 gated off", {6'h0, padOutB[1:0]}, 8'h00);
    @(negedge clk); tmrOvf = 1'b1;
    @(negedge clk); tmrOvf = 1'b0;
    #1 chk("R10 gated off after overflow", {6'h0, padOutB[1:0]}, 8'h00);
  endtask

  task automatic t_in_mode();
    logic [7:0] v;
    wr(3'b011, 8'hFF);
    padInB = 8'h02;
    rd(3'b010, v); chk("R11 pad read with strap", v, 8'h02);
    chk("R11 no drive", padOeB, 8'h00);
  endtask

  task automatic t_shared();
    padInC = 8'h21; padInD = 8'h01;
    #1 chk("R12 taps high", {5'h0, tmr0Clk, tmr1Clk, extInt}, 8'h07);
    padInC = 8'h20; padInD = 8'h00;
    #1 chk("R12 taps mixed", {5'h0, tmr0Clk, tmr1Clk, extInt}, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_dir();
    t_read();
    t_rmw();
    t_unimpl();
    t_pull();
    t_wake();
    t_buzz_off();
    t_buzz_on();
    t_buzz_gate();
    t_in_mode();
    t_shared();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule